// File: doc/BRIEF.md
# Multifunction Shift Register with Priority Controls

This block is a register of configurable width whose every bit is fed by a single four-way multiplexer. Through that multiplexer a bit can keep its value, take a parallel input bit, or take the value of a neighbour. The neighbour is the lower bit for a left shift and the upper bit for a right shift. A clear request forces the whole word to zero.

The block does not expose the multiplexer select. It has four independent active-high request pins instead: load, clear, shift-left and shift-right. A small resolver turns them into one select code by fixed priority, and load overrides everything else. Each shift direction has a serial input that fills the vacated end. A rotate pin makes the bit that leaves the word fill that end instead. A serial output shows the bit that a shift in progress pushes out.

Top module: `mfunc_reg`

## Requirements
- R1: With no request pin high, the stored word keeps its value across clock edges; the rotate pin alone changes nothing.
- R2: When the load pin is high at a rising edge, the word takes the parallel input.
- R3: Requests resolve as load over clear over shift-left over shift-right; with load high, clear, shifts and rotate have no effect, and with both shift pins high only the left shift happens.
- R4: When clear is the winning request, the word becomes all zeros at that rising edge.
- R5: A left shift moves every bit one place toward the MSB, drops the old MSB and puts the left serial input into bit 0.
- R6: A right shift moves every bit one place toward bit 0, drops the old bit 0 and puts the right serial input into the MSB.
- R7: With the rotate pin high, a right shift puts the old bit 0 into the MSB, and a left shift puts the old MSB into bit 0; the serial inputs are then ignored.
- R8: The serial output is combinational. It equals the current MSB while a left shift is the winning request, and the current bit 0 while a right shift wins. Otherwise it is 0.
- R9: The reset pin is active low and acts at the rising edge. It forces the word to zero regardless of every other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Parallel load request (highest priority) |
| clr_en | input | 1 | Synchronous clear request |
| shl_en | input | 1 | Shift-toward-MSB request |
| shr_en | input | 1 | Shift-toward-LSB request |
| rot_en | input | 1 | Rotate mode: refill from the departing bit |
| par_in | input | WIDTH | Parallel data for load |
| shl_in | input | 1 | Serial fill for bit 0 on a left shift |
| shr_in | input | 1 | Serial fill for the MSB on a right shift |
| q | output | WIDTH | Stored word |
| ser_out | output | 1 | Bit leaving the word during the current shift |

## Verification
The assertions assume that WIDTH is at least two and that every request and data pin is a clean 0 or 1 at each rising edge after reset is released. The stimulus changes inputs only on falling edges and holds them through the next rising edge. Pin combinations that conflict, such as load together with every other request, are applied on purpose so that the priority ordering is exercised.

// File: rtl/mfreg_pkg.sv
// Shared types for the multifunction register.
// Assumes: the select code is two bits wide; clear is carried beside it.
package mfreg_pkg;

    // Multiplexer select codes seen by every bit slice.
    typedef enum logic [1:0] {
        SEL_HOLD = 2'b00,
        SEL_SHR  = 2'b01,
        SEL_SHL  = 2'b10,
        SEL_LOAD = 2'b11
    } mux_sel_e;

    // Raw function requests gathered from the pins.
    typedef struct packed {
        logic ld;
        logic clr;
        logic shl;
        logic shr;
    } fn_req_t;

endpackage

// File: rtl/mfreg_prio.sv
// Priority resolver: turns independent request pins into one mux select.
// Order: load > clear > shift-left > shift-right > hold.
// Assumes: request pins are synchronous to clk.
module mfreg_prio
    import mfreg_pkg::*;
(
    input  fn_req_t  req,
    output mux_sel_e sel,
    output logic     zero
);

    // Resolve the winning request; clear rides on the hold code with zero forcing.
    always_comb begin
        sel  = SEL_HOLD;
        zero = 1'b0;
        if (req.ld) begin
            sel = SEL_LOAD;
        end else if (req.clr) begin
            zero = 1'b1;
        end else if (req.shl) begin
            sel = SEL_SHL;
        end else if (req.shr) begin
            sel = SEL_SHR;
        end
    end

endmodule

// File: rtl/mfreg_bitslice.sv
// One bit of the register's next-state logic: a four-way mux plus a zero force.
// Assumes: neighbour inputs are already wired to the correct adjacent bit or fill.
module mfreg_bitslice
    import mfreg_pkg::*;
(
    input  logic     cur,
    input  logic     par_bit,
    input  logic     from_lower,
    input  logic     from_upper,
    input  mux_sel_e sel,
    input  logic     zero,
    output logic     nxt
);

    // Pick the next value of this bit, then apply clear.
    always_comb begin
        case (sel)
            SEL_SHR:  nxt = from_upper;
            SEL_SHL:  nxt = from_lower;
            SEL_LOAD: nxt = par_bit;
            default:  nxt = cur;
        endcase
        if (zero) nxt = 1'b0;
    end

endmodule

// File: rtl/mfunc_reg.sv
// Multifunction register top: priority resolver, one mux slice per bit,
// state register and serial output.
// Assumes: WIDTH >= 2; all inputs synchronous to clk; reset synchronous, active low.
module mfunc_reg
    import mfreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             clr_en,
    input  logic             shl_en,
    input  logic             shr_en,
    input  logic             rot_en,
    input  logic [WIDTH-1:0] par_in,
    input  logic             shl_in,
    input  logic             shr_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);

    localparam int MSB = WIDTH - 1;

    fn_req_t        req;
    mux_sel_e       sel;
    logic           zero;
    logic           fill_lo;
    logic           fill_hi;
    logic [MSB:0]   q_r;
    logic [MSB:0]   nxt;
    logic [MSB:0]   lower_nb;
    logic [MSB:0]   upper_nb;

    // Collect the request pins.
    assign req = '{ld: ld_en, clr: clr_en, shl: shl_en, shr: shr_en};

    mfreg_prio u_prio (
        .req  (req),
        .sel  (sel),
        .zero (zero)
    );

    // Fill bits: serial inputs, or the departing bit in rotate mode.
    always_comb begin
        fill_lo = rot_en ? q_r[MSB] : shl_in;
        fill_hi = rot_en ? q_r[0]   : shr_in;
    end

    // Neighbour wiring and one slice per bit.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_lsb
                assign lower_nb[i] = fill_lo;
            end else begin : g_mid_lo
                assign lower_nb[i] = q_r[i-1];
            end
            if (i == MSB) begin : g_msb
                assign upper_nb[i] = fill_hi;
            end else begin : g_mid_hi
                assign upper_nb[i] = q_r[i+1];
            end
            mfreg_bitslice u_slice (
                .cur        (q_r[i]),
                .par_bit    (par_in[i]),
                .from_lower (lower_nb[i]),
                .from_upper (upper_nb[i]),
                .sel        (sel),
                .zero       (zero),
                .nxt        (nxt[i])
            );
        end
    endgenerate

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= nxt;
    end

    // Serial output: the bit leaving during the current shift.
    always_comb begin
        case (sel)
            SEL_SHL: ser_out = q_r[MSB];
            SEL_SHR: ser_out = q_r[0];
            default: ser_out = 1'b0;
        endcase
    end

    assign q = q_r;

    // R9
    reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (q_r == '0));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (q_r == $past(par_in)));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !ld_en) |=> (q_r == '0));

    // R5
    shl_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shl_en && !ld_en && !clr_en) |=>
        (q_r == {$past(q_r[MSB-1:0]), ($past(rot_en) ? $past(q_r[MSB]) : $past(shl_in))}));

    // R6
    shr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shr_en && !shl_en && !ld_en && !clr_en) |=>
        (q_r == {($past(rot_en) ? $past(q_r[0]) : $past(shr_in)), $past(q_r[MSB:1])}));

    // R1
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !clr_en && !shl_en && !shr_en) |=> $stable(q_r));

    // R8
    serout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shl_en && !shr_en) |-> (ser_out == 1'b0));

endmodule

// File: tb/tb_mfunc_reg.sv
module tb_mfunc_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ld_en, clr_en, shl_en, shr_en, rot_en;
    logic [W-1:0] par_in;
    logic         shl_in, shr_in;
    logic [W-1:0] q;
    logic         ser_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mfunc_reg #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .clr_en(clr_en),
        .shl_en(shl_en), .shr_en(shr_en), .rot_en(rot_en), .par_in(par_in),
        .shl_in(shl_in), .shr_in(shr_in), .q(q), .ser_out(ser_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive pins on a falling edge.
    task automatic drive(input logic l, input logic c, input logic sl, input logic sr,
                         input logic r, input logic [W-1:0] p, input logic si_l, input logic si_r);
        @(negedge clk);
        ld_en = l; clr_en = c; shl_en = sl; shr_en = sr; rot_en = r;
        par_in = p; shl_in = si_l; shr_in = si_r;
        #1;
    endtask

    // Let one rising edge pass, then settle.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, '0, 0, 0);
    endtask

    task automatic load(input logic [W-1:0] v);
        drive(1, 0, 0, 0, 0, v, 0, 0);
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1, 0, 0, 0, 0, 8'hFF, 1, 1);
        tick();
        tick();
        chk("R9 reset clears", q, 8'h00);
        idle();
        chk("R8 idle serial out", {7'd0, ser_out}, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_load_hold();
        load(8'hA5);
        chk("R2 load", q, 8'hA5);
        drive(0, 0, 0, 0, 1, 8'h00, 1, 1);
        tick();
        tick();
        chk("R1 hold with rotate only", q, 8'hA5);
    endtask

    task automatic t_load_priority();
        drive(1, 1, 1, 1, 1, 8'h3C, 1, 1);
        chk("R8 no serial out on load", {7'd0, ser_out}, 8'h00);
        tick();
        chk("R3 load beats all", q, 8'h3C);
    endtask

    task automatic t_clear();
        drive(0, 1, 1, 1, 0, 8'hFF, 1, 1);
        tick();
        chk("R4 clear beats shifts", q, 8'h00);
    endtask

    task automatic t_shift_left();
        load(8'h81);
        drive(0, 0, 1, 0, 0, 8'h00, 1, 0);
        chk("R8 serial out left", {7'd0, ser_out}, 8'h01);
        tick();
        chk("R5 shift left fill 1", q, 8'h03);
        drive(0, 0, 1, 0, 0, 8'h00, 0, 1);
        chk("R8 serial out left zero", {7'd0, ser_out}, 8'h00);
        tick();
        chk("R5 shift left fill 0", q, 8'h06);
    endtask

    task automatic t_shift_right();
        load(8'h81);
        drive(0, 0, 0, 1, 0, 8'h00, 1, 0);
        chk("R8 serial out right", {7'd0, ser_out}, 8'h01);
        tick();
        chk("R6 shift right fill 0", q, 8'h40);
        drive(0, 0, 0, 1, 0, 8'h00, 0, 1);
        tick();
        chk("R6 shift right fill 1", q, 8'hA0);
    endtask

    task automatic t_both_shifts();
        drive(0, 0, 1, 1, 0, 8'h00, 0, 1);
        chk("R3 left wins serial out", {7'd0, ser_out}, 8'h01);
        tick();
        chk("R3 left beats right", q, 8'h40);
    endtask

    task automatic t_rotate();
        load(8'h81);
        drive(0, 0, 0, 1, 1, 8'h00, 1, 0);
        tick();
        chk("R7 rotate right", q, 8'hC0);
        drive(0, 0, 1, 0, 1, 8'h00, 0, 1);
        tick();
        chk("R7 rotate left", q, 8'h81);
    endtask

    task automatic t_reset_mid();
        load(8'h5A);
        rst_n = 1'b0;
        drive(1, 0, 1, 0, 0, 8'hFF, 1, 0);
        tick();
        chk("R9 reset beats load", q, 8'h00);
        rst_n = 1'b1;
        idle();
        tick();
    endtask

    initial begin
        rst_n = 1'b0;
        ld_en = 0; clr_en = 0; shl_en = 0; shr_en = 0; rot_en = 0;
        par_in = '0; shl_in = 0; shr_in = 0;
        t_reset();
        t_load_hold();
        t_load_priority();
        t_clear();
        t_shift_left();
        t_shift_right();
        t_both_shifts();
        t_rotate();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule